// File: doc/BRIEF.md
# Dual-Register DDS Waveform Engine

A numerically controlled oscillator that turns a frequency word into a periodic 10-bit output code. A 28-bit phase accumulator adds one of two frequency words on every clock. One of two 12-bit phase offsets is then added to the upper bits of the running phase. The offset phase drives a sine lookup, a triangle, or a one-bit square wave. With clock rate `fclk` and frequency word `F`, the output repeats at `F * fclk / 2^28`.

A separate loader block supplies the control bits and the four registers. This block only runs the datapath. A control reset parks the phase at zero and the output at midscale. A sleep bit freezes the whole pipeline in place. A power-down bit forces the output to zero and raises a flag while the phase keeps running underneath.

The output is registered. A phase produced by the accumulator appears at the output two clocks later.

Top module: `dds_wave_engine`

## Requirements
- R1: On every clock with `ctl_reset`=0 and `sleep_clk`=0, the accumulator adds `freq1` when `freq_sel`=1 and `freq0` when `freq_sel`=0, wrapping modulo 2^28. The register that is not selected has no effect on the output.
- R2: The 12-bit offset phase is (accumulator[27:16] + `phase1` or `phase0`) mod 4096, chosen by `phase_sel`=1 or 0. One full turn is 4096 counts. The register that is not selected has no effect on the output.
- R3: Count c as the clock edges since `ctl_reset` fell on which `sleep_clk` was 0. For c >= 2, the output reflects the accumulator value c-2 steps in, that is ((c-2)*F mod 2^28).
- R4: With `bit_out_en`=0 and `mode_tri`=0, the output is 512 + round(511*sin(2*pi*(p+0.5)/4096)), within ±1, where p is the 12-bit offset phase. It is built from a quarter-wave table of 1024 entries.
- R5: With `bit_out_en`=0 and `mode_tri`=1, let u be the top 11 bits of the 28-bit offset phase. The output is u when u < 1024 and 2047-u otherwise.
- R6: With `bit_out_en`=1 and `sq_full`=1, the output is 1023 when bit 27 of the offset phase is 1 and 0 otherwise.
- R7: With `bit_out_en`=1 and `sq_full`=0, the output is a half-rate square at 1023 or 0. Its level starts at 0 after a control reset and toggles each time bit 27 of the offset phase goes from 0 to 1.
- R8: When `bit_out_en`=1 and `mode_tri`=1 are both set, the square output of R6 and R7 is produced and the triangle is not.
- R9: One edge after `ctl_reset`=1 (with `power_dn`=0), the output is 512. The accumulator, the offset phase and the half-rate square state are cleared, and running resumes per R3 once `ctl_reset` returns to 0.
- R10: On an edge with `sleep_clk`=1, the accumulator, the pipeline and the output hold their values. After `sleep_clk` returns to 0, the output continues as if those edges never happened.
- R11: One edge after `power_dn`=1, the output is 0 and `dac_off` is 1. This takes priority over `ctl_reset`. The accumulator keeps running, and `dac_off` is 0 one edge after `power_dn`=0.
- R12: While `rst_n`=0, the output is 512 and `dac_off` is 0, whatever the other inputs are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_reset | input | 1 | Control reset: phase to zero, output to midscale |
| freq_sel | input | 1 | Selects `freq1` (1) or `freq0` (0) as the step |
| phase_sel | input | 1 | Selects `phase1` (1) or `phase0` (0) as the offset |
| sleep_clk | input | 1 | Freezes the accumulator, pipeline and output |
| power_dn | input | 1 | Forces the output to zero and raises `dac_off` |
| mode_tri | input | 1 | Triangle instead of sine |
| bit_out_en | input | 1 | One-bit square output instead of the waveform |
| sq_full | input | 1 | Square from phase MSB (1) or half-rate divider (0) |
| freq0 | input | 28 | Frequency word 0 |
| freq1 | input | 28 | Frequency word 1 |
| phase0 | input | 12 | Phase offset 0 |
| phase1 | input | 12 | Phase offset 1 |
| wave_out | output | 10 | Registered output code |
| dac_off | output | 1 | Power-down indicator |

## Verification
A unit step of 2^16 sweeps every one of the 4096 sine phases, and a step of 2^17 covers every triangle code. A wrong fold of the quarter table, or a missing half-step offset, would show as a mirrored or shifted code in one quadrant. Large steps with maximal offsets force accumulator and offset wraps. A design that drops the carry or adds the offset to the wrong bits would drift away from the arithmetic phase sequence. An output a cycle early or late would break every comparison after the first. Sleep and power-down windows are opened mid-run. A design that let the accumulator run through sleep, or stopped it during power-down, would resume at the wrong phase. The half-rate square, and square-over-triangle priority, are checked edge by edge.

// File: rtl/dds_pkg.sv
package dds_pkg;

   typedef enum logic [1:0] {
      SHAPE_SINE    = 2'd0,
      SHAPE_TRI     = 2'd1,
      SHAPE_SQ_FULL = 2'd2,
      SHAPE_SQ_HALF = 2'd3
   } shape_e;

   // Square output outranks triangle, triangle outranks sine.
   function automatic shape_e pick_shape(input logic bit_out, input logic tri_m,
                                         input logic full_rate);
      if (bit_out)
         return full_rate ? SHAPE_SQ_FULL : SHAPE_SQ_HALF;
      else if (tri_m)
         return SHAPE_TRI;
      else
         return SHAPE_SINE;
   endfunction

endpackage

// File: rtl/dds_phase_accum.sv
module dds_phase_accum #(
   parameter int ACC_W = 28,
   parameter int PH_W  = 12,
   parameter int PO_W  = 12
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             hold,
   input  logic [ACC_W-1:0] step,
   input  logic [PH_W-1:0]  offset,
   output logic [PO_W-1:0]  ph_q,
   output logic             half_q
);

   logic [ACC_W-1:0] acc_q;
   logic [PO_W-1:0]  ph_next;

   // Offset lands on the top PH_W bits; extra resolution bits pass through.
   generate
      if (PO_W > PH_W) begin : g_wide
         assign ph_next = {acc_q[ACC_W-1 -: PH_W] + offset,
                           acc_q[ACC_W-PH_W-1 -: (PO_W-PH_W)]};
      end else begin : g_narrow
         assign ph_next = acc_q[ACC_W-1 -: PH_W] + offset;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc_q  <= '0;
         ph_q   <= '0;
         half_q <= 1'b0;
      end else if (clr) begin
         acc_q  <= '0;
         ph_q   <= '0;
         half_q <= 1'b0;
      end else if (!hold) begin
         acc_q <= acc_q + step;
         ph_q  <= ph_next;
         if (ph_next[PO_W-1] && !ph_q[PO_W-1])
            half_q <= ~half_q;
      end
   end

   // R9
   clr_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (acc_q == '0) && (ph_q == '0) && !half_q);

   // R10
   hold_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (hold && !clr) |=> $stable(acc_q) && $stable(ph_q) && $stable(half_q));

   // R7
   half_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr && !hold && !ph_q[PO_W-1]) |=> ($changed(half_q) -> $rose(ph_q[PO_W-1])));

endmodule

// File: rtl/dds_sine_lut.sv
module dds_sine_lut #(
   parameter int PH_W  = 12,
   parameter int OUT_W = 10
) (
   input  logic [PH_W-1:0]  phase,
   output logic [OUT_W-1:0] code
);

   localparam int LUT_AW = PH_W - 2;
   localparam int DEPTH  = 1 << LUT_AW;
   localparam int AMP_W  = OUT_W - 1;
   localparam int AMP    = (1 << AMP_W) - 1;
   localparam logic [OUT_W-1:0] MID = OUT_W'(1 << AMP_W);
   localparam longint PI_Q30 = 64'sd3373259426;

   // Quarter-wave magnitude at (idx + 0.5) steps, fixed-point Taylor series.
   function automatic logic [AMP_W-1:0] quarter_val(input int idx);
      longint th, th2, term, s, v;
      th   = ((2 * longint'(idx) + 1) * PI_Q30) >>> (LUT_AW + 2);
      th2  = (th * th) >>> 30;
      term = th;
      s    = th;
      for (int k = 1; k <= 6; k++) begin
         term = ((term * th2) >>> 30) / longint'((2 * k) * (2 * k + 1));
         if ((k % 2) == 1) s = s - term;
         else              s = s + term;
      end
      v = (s * longint'(AMP) + (64'sd1 <<< 29)) >>> 30;
      if (v > longint'(AMP)) v = longint'(AMP);
      if (v < 0)             v = 0;
      return AMP_W'(v);
   endfunction

   logic [AMP_W-1:0] rom [DEPTH];

   generate
      for (genvar gi = 0; gi < DEPTH; gi++) begin : g_rom
         assign rom[gi] = quarter_val(gi);
      end
   endgenerate

   logic [LUT_AW-1:0] idx;
   logic [AMP_W-1:0]  mag;

   always_comb begin
      idx  = phase[PH_W-2] ? ~phase[LUT_AW-1:0] : phase[LUT_AW-1:0];
      mag  = rom[idx];
      code = phase[PH_W-1] ? (MID - OUT_W'(mag)) : (MID + OUT_W'(mag));
   end

endmodule

// File: rtl/dds_wave_shaper.sv
module dds_wave_shaper
   import dds_pkg::*;
#(
   parameter int PH_W  = 12,
   parameter int OUT_W = 10,
   parameter int PO_W  = 12
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             hold,
   input  logic             pdn,
   input  shape_e           shape,
   input  logic [PO_W-1:0]  ph,
   input  logic             half,
   output logic [OUT_W-1:0] wave_q,
   output logic             off_q
);

   localparam logic [OUT_W-1:0] MID = OUT_W'(1 << (OUT_W - 1));

   logic [OUT_W-1:0] sine_code;
   logic [OUT_W-1:0] tri_code;
   logic [OUT_W-1:0] shaped;

   dds_sine_lut #(.PH_W(PH_W), .OUT_W(OUT_W)) u_lut (
      .phase (ph[PO_W-1 -: PH_W]),
      .code  (sine_code)
   );

   // Triangle: the top OUT_W+1 phase bits, folded in the second half.
   assign tri_code = ph[PO_W-1] ? ~ph[PO_W-2 -: OUT_W] : ph[PO_W-2 -: OUT_W];

   always_comb begin
      unique case (shape)
         SHAPE_SINE:    shaped = sine_code;
         SHAPE_TRI:     shaped = tri_code;
         SHAPE_SQ_FULL: shaped = {OUT_W{ph[PO_W-1]}};
         SHAPE_SQ_HALF: shaped = {OUT_W{half}};
         default:       shaped = MID;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wave_q <= MID;
         off_q  <= 1'b0;
      end else begin
         off_q <= pdn;
         if (pdn)
            wave_q <= '0;
         else if (clr)
            wave_q <= MID;
         else if (!hold)
            wave_q <= shaped;
      end
   end

   // R11
   pdn_force_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pdn |=> (wave_q == '0) && off_q);

   // R11
   pdn_flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !pdn |=> !off_q);

   // R9
   clr_mid_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (clr && !pdn) |=> (wave_q == MID));

   // R10
   hold_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (hold && !clr && !pdn) |=> $stable(wave_q));

   // R8
   square_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!pdn && !clr && !hold && (shape == SHAPE_SQ_FULL || shape == SHAPE_SQ_HALF))
      |=> (wave_q == '0) || (wave_q == '1));

endmodule

// File: rtl/dds_wave_engine.sv
module dds_wave_engine
   import dds_pkg::*;
#(
   parameter int ACC_W = 28,
   parameter int PH_W  = 12,
   parameter int OUT_W = 10
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ctl_reset,
   input  logic             freq_sel,
   input  logic             phase_sel,
   input  logic             sleep_clk,
   input  logic             power_dn,
   input  logic             mode_tri,
   input  logic             bit_out_en,
   input  logic             sq_full,
   input  logic [ACC_W-1:0] freq0,
   input  logic [ACC_W-1:0] freq1,
   input  logic [PH_W-1:0]  phase0,
   input  logic [PH_W-1:0]  phase1,
   output logic [OUT_W-1:0] wave_out,
   output logic             dac_off
);

   // Phase bits carried past the accumulator: enough for sine and triangle.
   localparam int PO_W = (OUT_W + 1 > PH_W) ? (OUT_W + 1) : PH_W;

   generate
      if (PH_W < 4 || PH_W > 14) begin : g_bad_ph
         $error("dds_wave_engine: PH_W must lie in 4..14");
      end
      if (OUT_W < 2) begin : g_bad_out
         $error("dds_wave_engine: OUT_W must be at least 2");
      end
      if (PO_W > ACC_W) begin : g_bad_acc
         $error("dds_wave_engine: ACC_W too narrow for phase and output widths");
      end
   endgenerate

   logic [ACC_W-1:0] step;
   logic [PH_W-1:0]  offset;
   logic [PO_W-1:0]  ph;
   logic             half;
   shape_e           shape;

   assign step   = freq_sel  ? freq1  : freq0;
   assign offset = phase_sel ? phase1 : phase0;
   assign shape  = pick_shape(bit_out_en, mode_tri, sq_full);

   dds_phase_accum #(.ACC_W(ACC_W), .PH_W(PH_W), .PO_W(PO_W)) u_acc (
      .clk    (clk),
      .rst_n  (rst_n),
      .clr    (ctl_reset),
      .hold   (sleep_clk),
      .step   (step),
      .offset (offset),
      .ph_q   (ph),
      .half_q (half)
   );

   dds_wave_shaper #(.PH_W(PH_W), .OUT_W(OUT_W), .PO_W(PO_W)) u_shape (
      .clk    (clk),
      .rst_n  (rst_n),
      .clr    (ctl_reset),
      .hold   (sleep_clk),
      .pdn    (power_dn),
      .shape  (shape),
      .ph     (ph),
      .half   (half),
      .wave_q (wave_out),
      .off_q  (dac_off)
   );

endmodule

// File: tb/sim_dds_wave_engine.sv
`timescale 1ns/1ps
module sim_dds_wave_engine;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        ctl_reset = 1'b1;
   logic        freq_sel = 1'b0;
   logic        phase_sel = 1'b0;
   logic        sleep_clk = 1'b0;
   logic        power_dn = 1'b0;
   logic        mode_tri = 1'b0;
   logic        bit_out_en = 1'b0;
   logic        sq_full = 1'b0;
   logic [27:0] freq0 = '0;
   logic [27:0] freq1 = '0;
   logic [11:0] phase0 = '0;
   logic [11:0] phase1 = '0;
   logic [9:0]  wave_out;
   logic        dac_off;

   always #4 clk = ~clk;

   dds_wave_engine u0 (
      .clk(clk), .rst_n(rst_n), .ctl_reset(ctl_reset), .freq_sel(freq_sel),
      .phase_sel(phase_sel), .sleep_clk(sleep_clk), .power_dn(power_dn),
      .mode_tri(mode_tri), .bit_out_en(bit_out_en), .sq_full(sq_full),
      .freq0(freq0), .freq1(freq1), .phase0(phase0), .phase1(phase1),
      .wave_out(wave_out), .dac_off(dac_off)
   );

   int     checks = 0;
   int     errors = 0;
   bit     done = 1'b0;
   longint c;
   bit     half_m;
   bit     msb_prev;

   task automatic check(input string tag, input int got, input int exp, input int tol);
      int d;
      checks++;
      d = got - exp;
      if (d < 0) d = -d;
      if (d > tol) begin
         errors++;
         $display("FAIL %s: got %0d expected %0d", tag, got, exp);
      end
   endtask

   // 28-bit offset phase after k accumulator steps (R1, R2).
   function automatic longint ph_of(input longint k);
      longint f, p;
      f = freq_sel  ? longint'(freq1)  : longint'(freq0);
      p = phase_sel ? longint'(phase1) : longint'(phase0);
      return (k * f + (p << 16)) & ((64'sd1 << 28) - 1);
   endfunction

   function automatic int exp_sine(input longint ph);
      real a;
      a = 2.0 * 3.141592653589793 * (real'(ph >> 16) + 0.5) / 4096.0;
      return $rtoi(512.0 + 511.0 * $sin(a) + 0.5);
   endfunction

   function automatic int exp_tri(input longint ph);
      int u;
      u = int'(ph >> 17);
      return (u < 1024) ? u : (2047 - u);
   endfunction

   // One clock: sample just after the negedge, before inputs change.
   task automatic step();
      longint ph;
      bit     m;
      @(negedge clk);
      if (!sleep_clk) begin
         c++;
         if (c >= 2) begin
            m = ph_of(c - 2)[27];
            if (m && !msb_prev) half_m = ~half_m;
            msb_prev = m;
         end
      end
      if (power_dn) begin
         check("R11 forced level", int'(wave_out), 0, 0);
         check("R11 flag set", int'(dac_off), 1, 0);
      end else begin
         check("R11 flag clear", int'(dac_off), 0, 0);
         if (c >= 2) begin
            ph = ph_of(c - 2);
            if (bit_out_en && mode_tri)
               check("R8 square over triangle", int'(wave_out),
                     sq_full ? (ph[27] ? 1023 : 0) : (half_m ? 1023 : 0), 0);
            else if (bit_out_en && sq_full)
               check("R6 full-rate square (R3)", int'(wave_out), ph[27] ? 1023 : 0, 0);
            else if (bit_out_en)
               check("R7 half-rate square (R3)", int'(wave_out), half_m ? 1023 : 0, 0);
            else if (mode_tri)
               check("R5 triangle (R1 R2 R3)", int'(wave_out), exp_tri(ph), 0);
            else
               check("R4 sine (R1 R2 R3 R10)", int'(wave_out), exp_sine(ph), 1);
         end
      end
   endtask

   task automatic start_run(input logic [27:0] f0, input logic [27:0] f1,
                            input logic [11:0] p0, input logic [11:0] p1,
                            input bit fs, input bit ps, input bit tm,
                            input bit boe, input bit sqf);
      @(negedge clk);
      freq0 = f0; freq1 = f1; phase0 = p0; phase1 = p1;
      freq_sel = fs; phase_sel = ps; mode_tri = tm; bit_out_en = boe; sq_full = sqf;
      sleep_clk = 1'b0; power_dn = 1'b0; ctl_reset = 1'b1;
      @(negedge clk);
      check("R9 midscale on control reset", int'(wave_out), 512, 0);
      ctl_reset = 1'b0;
      c = 0; half_m = 1'b0; msb_prev = 1'b0;
   endtask

   initial begin
      // R12: asynchronous reset state, power_dn ignored while held
      repeat (3) @(negedge clk);
      check("R12 reset level", int'(wave_out), 512, 0);
      check("R12 reset flag", int'(dac_off), 0, 0);
      power_dn = 1'b1;
      @(negedge clk);
      check("R12 reset dominates level", int'(wave_out), 512, 0);
      check("R12 reset dominates flag", int'(dac_off), 0, 0);
      power_dn = 1'b0;
      rst_n = 1'b1;

      // Exhaustive sine sweep: one phase count per clock, R1 R4
      start_run(28'h0010000, 28'h0ABCDEF, 12'h000, 12'h7FF, 0, 0, 0, 0, 0);
      repeat (4100) step();

      // Second registers selected, large step with wraps, R1 R2
      start_run(28'h0000100, 28'h0ABCDEF, 12'h123, 12'hFFF, 1, 1, 0, 0, 0);
      repeat (300) step();

      // Exhaustive triangle sweep, R5
      start_run(28'h0020000, 28'h0000001, 12'h155, 12'h000, 0, 0, 1, 0, 0);
      repeat (2100) step();

      // Fast triangle with offset wrap, R5
      start_run(28'h0000001, 28'h0401234, 12'h000, 12'hF00, 1, 1, 1, 0, 0);
      repeat (200) step();

      // Full-rate square, R6
      start_run(28'd6710886, 28'h0000000, 12'h400, 12'h000, 0, 0, 0, 1, 1);
      repeat (200) step();

      // Half-rate square, R7
      start_run(28'd6710886, 28'h0000000, 12'hC00, 12'h000, 0, 0, 0, 1, 0);
      repeat (300) step();

      // Square wins over triangle, R8 (both rates)
      start_run(28'd5000000, 28'h0000000, 12'h000, 12'h000, 0, 0, 1, 1, 1);
      repeat (100) step();
      start_run(28'd5000000, 28'h0000000, 12'h000, 12'h000, 0, 0, 1, 1, 0);
      repeat (200) step();

      // Sleep window mid-run, R10
      start_run(28'h0123457, 28'h0000000, 12'h0A0, 12'h000, 0, 0, 0, 0, 0);
      repeat (60) step();
      sleep_clk = 1'b1;
      repeat (20) step();
      sleep_clk = 1'b0;
      repeat (60) step();

      // Power-down window, accumulator keeps running, R11
      start_run(28'h0123457, 28'h0000000, 12'h000, 12'h000, 0, 0, 0, 0, 0);
      repeat (40) step();
      power_dn = 1'b1;
      repeat (15) step();
      power_dn = 1'b0;
      repeat (40) step();

      // Power-down outranks control reset, R11 then R9
      @(negedge clk);
      ctl_reset = 1'b1;
      power_dn = 1'b1;
      @(negedge clk);
      check("R11 over control reset level", int'(wave_out), 0, 0);
      check("R11 over control reset flag", int'(dac_off), 1, 0);
      power_dn = 1'b0;
      @(negedge clk);
      check("R9 midscale after power-down", int'(wave_out), 512, 0);
      check("R11 flag clears", int'(dac_off), 0, 0);

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      #(200000 * 8);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

endmodule